// File: doc/BRIEF.md
# ADC Sampling Sequencer

This block is the control state machine of an always-on analog monitor. It drives the power-down pin and the channel select of an external multi-channel ADC. Each round it collects one conversion per channel, then judges the filter match vector that the window comparators produce for that round. Three ways of working are offered:

- **Single shot:** one round, then a done pulse; filter results are ignored.
- **Continuous normal power:** back-to-back rounds with the ADC kept powered.
- **Low power:** a periodic wake-sample-sleep loop. Once enough identical matches have been seen in a row, it hands over to continuous sampling.

A match is reported only after a programmable number of consecutive rounds have returned the same non-zero vector. The report is a one-cycle pulse together with the vector. At that moment a snapshot of the channel values is taken. All configuration arrives as static input ports, already in the always-on clock domain.

Top module: `adc_seq_fsm`

## Requirements
- R1: While the enable input is low, `adc_pd_o` is 1, `adc_chsel_o` is 0 and neither pulse output fires.
- R2: After enabling, `adc_pd_o` falls in the following cycle. `adc_chsel_o` stays 0 for exactly `cfg_pwrup_time_i`+1 cycles with the ADC powered, then selects the first channel.
- R3: `adc_chsel_o` is one-hot, bit i selecting channel i. A round selects channel 0 until a cycle with `adc_valid_i`=1, then channel 1 likewise. One evaluation cycle follows with no channel selected and the ADC still powered.
- R4: With single shot set, the evaluation cycle is followed by one cycle of `oneshot_done_o`=1. `match_pulse_o` never fires whatever the match vector is. The ADC then stays powered down until enable is dropped.
- R5: With low-power mode off, the ADC is never powered down while enabled and no reset is applied.
- R6: In low-power mode, an evaluation that does not reach the low-power count powers the ADC down for max(`cfg_wakeup_time_i`,1) cycles, then repeats the power-up wait.
- R7: In low-power mode, once the low-power count of consecutive identical non-zero matches is reached, the ADC stays powered and normal-power rounds follow.
- R8: Consecutive-match counting works as follows. An all-zero vector sets the count to 0. A non-zero vector different from the previous round sets it to 1. An identical non-zero vector adds 1. A programmed count of 0 acts as 1.
- R9: In normal power, when the count reaches `cfg_np_count_i`, `match_pulse_o` is 1 for one cycle, the cycle after the evaluation, with `match_val_o` equal to the vector. The count then restarts from 0.
- R10: Channel i of `ch_last_o` (bits i*10 upward) takes `adc_data_i` in the cycle after it is accepted. `ch_hold_o` takes the whole of `ch_last_o` in the cycle `match_pulse_o` rises and is otherwise unchanged.
- R11: While `cfg_soft_rst_i` is 1, `adc_pd_o` is 1 in the same cycle. The sequencer, timer and counters return to their initial state, while `ch_last_o` is kept.
- R12: Dropping enable partway through a round sets `adc_pd_o` to 1 in the same cycle and clears the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_enable_i | input | 1 | Run the sequencer |
| cfg_oneshot_i | input | 1 | Single round, then done |
| cfg_lp_mode_i | input | 1 | Start with low-power periodic sampling |
| cfg_pwrup_time_i | input | 4 | Power-up wait in cycles |
| cfg_wakeup_time_i | input | 24 | Sleep length between low-power rounds |
| cfg_lp_count_i | input | 8 | Identical matches needed to leave low power |
| cfg_np_count_i | input | 16 | Identical matches needed to report |
| cfg_soft_rst_i | input | 1 | Hold every state machine and timer in reset |
| adc_pd_o | output | 1 | ADC power-down |
| adc_chsel_o | output | 2 | One-hot channel select |
| adc_data_i | input | 10 | Conversion result |
| adc_valid_i | input | 1 | Conversion result valid |
| match_vec_i | input | 8 | Filter match vector of the current round |
| match_pulse_o | output | 1 | Debounced match report pulse |
| match_val_o | output | 8 | Last reported match vector |
| oneshot_done_o | output | 1 | Single-shot round complete pulse |
| ch_last_o | output | 20 | Latest value per channel |
| ch_hold_o | output | 20 | Channel values captured at the last report |

## Verification
The bench targets the count boundaries. A debounce that counted an all-zero vector, or that failed to restart on a changed vector, would report matches during alternating or idle input. A programmed count or wakeup time of zero must act as one; a design that underflowed there would sleep for a whole timer wrap or never report. It also checks the exact length of the power-up wait, which an off-by-one would shift by a cycle. Finally, it checks that soft reset and disable raise power-down in the same cycle while leaving the latest channel values intact; a registered power-down or a cleared value store would show there.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PWRUP = 3'd1,
        ST_CONV  = 3'd2,
        ST_EVAL  = 3'd3,
        ST_SLEEP = 3'd4,
        ST_DONE  = 3'd5
    } seq_state_e;

endpackage

// File: rtl/adc_seq_debounce.sv
module adc_seq_debounce #(
    parameter int NUM_FILT = 8,
    parameter int CNT_W    = 16
) (
    input  logic [NUM_FILT-1:0] match_i,
    input  logic [NUM_FILT-1:0] prev_i,
    input  logic [CNT_W-1:0]    cnt_i,
    input  logic [CNT_W-1:0]    target_i,
    output logic [CNT_W-1:0]    cnt_o,
    output logic                hit_o
);
    logic [CNT_W-1:0] tgt_eff;

    always_comb begin
        if (match_i == '0) begin
            cnt_o = '0;
        end else if (match_i == prev_i) begin
            cnt_o = (&cnt_i) ? cnt_i : cnt_i + 1'b1;
        end else begin
            cnt_o = CNT_W'(1);
        end
        tgt_eff = (target_i == '0) ? CNT_W'(1) : target_i;
        hit_o   = (match_i != '0) && (cnt_o >= tgt_eff);
    end
endmodule

// File: rtl/adc_seq_chan_store.sv
module adc_seq_chan_store #(
    parameter int DATA_W = 10
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_last_i,
    input  logic              load_hold_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] last_o,
    output logic [DATA_W-1:0] hold_o
);
    logic [DATA_W-1:0] last_d, last_q, hold_d, hold_q;

    always_comb begin
        last_d = load_last_i ? data_i : last_q;
        hold_d = load_hold_i ? last_q : hold_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            last_q <= '0;
            hold_q <= '0;
        end else begin
            last_q <= last_d;
            hold_q <= hold_d;
        end
    end

    assign last_o = last_q;
    assign hold_o = hold_q;
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH   = 2,
    parameter int DATA_W   = 10,
    parameter int NUM_FILT = 8,
    parameter int PWRUP_W  = 4,
    parameter int WAKE_W   = 24,
    parameter int LP_W     = 8,
    parameter int NP_W     = 16
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     cfg_enable_i,
    input  logic                     cfg_oneshot_i,
    input  logic                     cfg_lp_mode_i,
    input  logic [PWRUP_W-1:0]       cfg_pwrup_time_i,
    input  logic [WAKE_W-1:0]        cfg_wakeup_time_i,
    input  logic [LP_W-1:0]          cfg_lp_count_i,
    input  logic [NP_W-1:0]          cfg_np_count_i,
    input  logic                     cfg_soft_rst_i,
    output logic                     adc_pd_o,
    output logic [NUM_CH-1:0]        adc_chsel_o,
    input  logic [DATA_W-1:0]        adc_data_i,
    input  logic                     adc_valid_i,
    input  logic [NUM_FILT-1:0]      match_vec_i,
    output logic                     match_pulse_o,
    output logic [NUM_FILT-1:0]      match_val_o,
    output logic                     oneshot_done_o,
    output logic [NUM_CH*DATA_W-1:0] ch_last_o,
    output logic [NUM_CH*DATA_W-1:0] ch_hold_o
);
    localparam int TMR_W    = (WAKE_W > PWRUP_W) ? WAKE_W : PWRUP_W;
    localparam int CNT_W    = (NP_W > LP_W) ? NP_W : LP_W;
    localparam int CH_IDX_W = (NUM_CH > 2) ? $clog2(NUM_CH) : 1;

    typedef struct packed {
        seq_state_e            state;
        logic [TMR_W-1:0]      timer;
        logic [CNT_W-1:0]      cnt;
        logic [NUM_FILT-1:0]   prev;
        logic                  lp_phase;
        logic [CH_IDX_W-1:0]   ch_idx;
        logic                  match_pulse;
        logic [NUM_FILT-1:0]   match_val;
        logic                  oneshot_done;
    } seq_regs_t;

    seq_regs_t          r_d, r_q;
    logic               go;
    logic [NUM_CH-1:0]  ld_last;
    logic               ld_hold;
    logic [CNT_W-1:0]   db_target, db_cnt;
    logic               db_hit;
    logic [TMR_W:0]     tmr_inc;

    assign go        = cfg_enable_i && !cfg_soft_rst_i;
    assign db_target = r_q.lp_phase ? CNT_W'(cfg_lp_count_i) : CNT_W'(cfg_np_count_i);
    assign tmr_inc   = {1'b0, r_q.timer} + 1'b1;

    adc_seq_debounce #(
        .NUM_FILT (NUM_FILT),
        .CNT_W    (CNT_W)
    ) u_debounce (
        .match_i  (match_vec_i),
        .prev_i   (r_q.prev),
        .cnt_i    (r_q.cnt),
        .target_i (db_target),
        .cnt_o    (db_cnt),
        .hit_o    (db_hit)
    );

    always_comb begin
        r_d              = r_q;
        r_d.match_pulse  = 1'b0;
        r_d.oneshot_done = 1'b0;
        ld_last          = '0;
        ld_hold          = 1'b0;
        if (!go) begin
            r_d.state    = ST_IDLE;
            r_d.timer    = '0;
            r_d.cnt      = '0;
            r_d.prev     = '0;
            r_d.lp_phase = 1'b0;
            r_d.ch_idx   = '0;
        end else begin
            unique case (r_q.state)
                ST_IDLE: begin
                    r_d.state    = ST_PWRUP;
                    r_d.timer    = '0;
                    r_d.lp_phase = cfg_lp_mode_i;
                end
                ST_PWRUP: begin
                    if (r_q.timer == TMR_W'(cfg_pwrup_time_i)) begin
                        r_d.state  = ST_CONV;
                        r_d.timer  = '0;
                        r_d.ch_idx = '0;
                    end else begin
                        r_d.timer = r_q.timer + 1'b1;
                    end
                end
                ST_CONV: begin
                    if (adc_valid_i) begin
                        ld_last[r_q.ch_idx] = 1'b1;
                        if (r_q.ch_idx == CH_IDX_W'(NUM_CH - 1)) begin
                            r_d.state  = ST_EVAL;
                            r_d.ch_idx = '0;
                        end else begin
                            r_d.ch_idx = r_q.ch_idx + 1'b1;
                        end
                    end
                end
                ST_EVAL: begin
                    r_d.prev = match_vec_i;
                    if (cfg_oneshot_i) begin
                        r_d.oneshot_done = 1'b1;
                        r_d.state        = ST_DONE;
                    end else if (r_q.lp_phase) begin
                        if (db_hit) begin
                            r_d.lp_phase = 1'b0;
                            r_d.cnt      = '0;
                            r_d.state    = ST_CONV;
                        end else begin
                            r_d.cnt   = db_cnt;
                            r_d.timer = '0;
                            r_d.state = ST_SLEEP;
                        end
                    end else begin
                        r_d.state = ST_CONV;
                        if (db_hit) begin
                            r_d.match_pulse = 1'b1;
                            r_d.match_val   = match_vec_i;
                            r_d.cnt         = '0;
                            ld_hold         = 1'b1;
                        end else begin
                            r_d.cnt = db_cnt;
                        end
                    end
                end
                ST_SLEEP: begin
                    if (tmr_inc >= (TMR_W + 1)'(cfg_wakeup_time_i)) begin
                        r_d.state = ST_PWRUP;
                        r_d.timer = '0;
                    end else begin
                        r_d.timer = tmr_inc[TMR_W-1:0];
                    end
                end
                ST_DONE: r_d.state = ST_DONE;
                default: r_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        adc_seq_chan_store #(
            .DATA_W (DATA_W)
        ) u_store (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .load_last_i (ld_last[g]),
            .load_hold_i (ld_hold),
            .data_i      (adc_data_i),
            .last_o      (ch_last_o[g*DATA_W +: DATA_W]),
            .hold_o      (ch_hold_o[g*DATA_W +: DATA_W])
        );
    end

    assign adc_pd_o = !(go && (r_q.state == ST_PWRUP || r_q.state == ST_CONV ||
                               r_q.state == ST_EVAL));
    assign adc_chsel_o    = (go && r_q.state == ST_CONV) ? (NUM_CH'(1) << r_q.ch_idx) : '0;
    assign match_pulse_o  = r_q.match_pulse;
    assign match_val_o    = r_q.match_val;
    assign oneshot_done_o = r_q.oneshot_done;
endmodule

// File: rtl/adc_seq_fsm_chk.sv
module adc_seq_fsm_chk #(
    parameter int NUM_CH = 2,
    parameter int DATA_W = 10
) (
    input logic                     clk_i,
    input logic                     rst_ni,
    input logic                     cfg_enable_i,
    input logic                     cfg_soft_rst_i,
    input logic                     adc_pd_o,
    input logic [NUM_CH-1:0]        adc_chsel_o,
    input logic                     match_pulse_o,
    input logic                     oneshot_done_o,
    input logic [NUM_CH*DATA_W-1:0] ch_hold_o
);
    AST_OFF_POWERED_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cfg_enable_i |-> adc_pd_o); // R1
    AST_CHSEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(adc_chsel_o)); // R3
    AST_CHSEL_NEEDS_POWER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (adc_chsel_o != '0) |-> !adc_pd_o); // R3
    AST_PULSES_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(match_pulse_o && oneshot_done_o)); // R4
    AST_ONESHOT_THEN_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        oneshot_done_o |-> adc_pd_o); // R4
    AST_MATCH_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        match_pulse_o |=> !match_pulse_o); // R9
    AST_HOLD_ONLY_ON_REPORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !match_pulse_o |-> $stable(ch_hold_o)); // R10
    AST_SOFTRST_NO_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_soft_rst_i |=> (adc_chsel_o == '0)); // R11
endmodule

bind adc_seq_fsm adc_seq_fsm_chk #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W)
) u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .cfg_enable_i   (cfg_enable_i),
    .cfg_soft_rst_i (cfg_soft_rst_i),
    .adc_pd_o       (adc_pd_o),
    .adc_chsel_o    (adc_chsel_o),
    .match_pulse_o  (match_pulse_o),
    .oneshot_done_o (oneshot_done_o),
    .ch_hold_o      (ch_hold_o)
);

// File: tb/tb_adc_seq_fsm.sv
module tb_adc_seq_fsm;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0, oneshot = 1'b0, lp = 1'b0, srst = 1'b0;
    logic [3:0]  pwrup = 4'd2;
    logic [23:0] wake = 24'd5;
    logic [7:0]  lpcnt = 8'd2;
    logic [15:0] npcnt = 16'd3;
    logic [9:0]  adata = '0;
    logic        avalid = 1'b0;
    logic [7:0]  mvec = '0;
    logic        pd, mpulse, odone;
    logic [1:0]  chsel;
    logic [7:0]  mval;
    logic [19:0] clast, chold;

    int errors = 0, checks = 0;

    always #5 clk = ~clk;

    adc_seq_fsm dut (
        .clk_i(clk), .rst_ni(rst_n), .cfg_enable_i(en), .cfg_oneshot_i(oneshot),
        .cfg_lp_mode_i(lp), .cfg_pwrup_time_i(pwrup), .cfg_wakeup_time_i(wake),
        .cfg_lp_count_i(lpcnt), .cfg_np_count_i(npcnt), .cfg_soft_rst_i(srst),
        .adc_pd_o(pd), .adc_chsel_o(chsel), .adc_data_i(adata), .adc_valid_i(avalid),
        .match_vec_i(mvec), .match_pulse_o(mpulse), .match_val_o(mval),
        .oneshot_done_o(odone), .ch_last_o(clast), .ch_hold_o(chold)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural reference: 0 idle, 1 power-up, 2 convert, 3 evaluate, 4 sleep, 5 done
    int          m_st = 0, m_tmr = 0, m_cnt = 0, m_ci = 0;
    logic [7:0]  m_prev = '0, m_mval = '0;
    logic        m_lp = 1'b0, m_pulse = 1'b0, m_done = 1'b0;
    logic [9:0]  m_last [2] = '{default: '0};
    logic [9:0]  m_hold [2] = '{default: '0};

    always @(posedge clk) begin
        int nc, tgt;
        m_pulse = 1'b0;
        m_done  = 1'b0;
        if (!rst_n || !en || srst) begin
            m_st = 0; m_tmr = 0; m_cnt = 0; m_ci = 0; m_prev = '0; m_lp = 1'b0;
            if (!rst_n) begin
                m_mval = '0; m_last = '{default: '0}; m_hold = '{default: '0};
            end
        end else begin
            case (m_st)
                0: begin m_st = 1; m_tmr = 0; m_lp = lp; end
                1: if (m_tmr == int'(pwrup)) begin m_st = 2; m_tmr = 0; m_ci = 0; end
                   else m_tmr++;
                2: if (avalid) begin
                       m_last[m_ci] = adata;
                       if (m_ci == 1) begin m_st = 3; m_ci = 0; end else m_ci++;
                   end
                3: begin
                    if (mvec == 0) nc = 0;
                    else if (mvec == m_prev) nc = (m_cnt == 65535) ? m_cnt : m_cnt + 1;
                    else nc = 1;
                    tgt = m_lp ? int'(lpcnt) : int'(npcnt);
                    if (tgt == 0) tgt = 1;
                    if (oneshot) begin m_done = 1'b1; m_st = 5; end
                    else if (m_lp) begin
                        if (mvec != 0 && nc >= tgt) begin m_lp = 1'b0; m_cnt = 0; m_st = 2; end
                        else begin m_cnt = nc; m_tmr = 0; m_st = 4; end
                    end else begin
                        m_st = 2;
                        if (mvec != 0 && nc >= tgt) begin
                            m_pulse = 1'b1; m_mval = mvec; m_cnt = 0; m_hold = m_last;
                        end else m_cnt = nc;
                    end
                    m_prev = mvec;
                end
                4: if (m_tmr + 1 >= int'(wake)) begin m_st = 1; m_tmr = 0; end
                   else m_tmr++;
                default: m_st = 5;
            endcase
        end
    end

    // Comparison, ADC responder and event counters at the falling edge
    int   lat = 0, os_cnt = 0, mp_cnt = 0, pd_rise = 0, low_streak = 0, gap = 0;
    logic meas_gap = 1'b0, pd_prev = 1'b1;

    always @(negedge clk) begin
        logic go_now, pd_exp;
        logic [1:0] sel_exp;
        if (rst_n) begin
            go_now  = en && !srst;
            pd_exp  = !(go_now && (m_st == 1 || m_st == 2 || m_st == 3));
            sel_exp = (go_now && m_st == 2) ? 2'(1 << m_ci) : 2'b00;
            chk("R1", "adc_pd", 64'(pd), 64'(pd_exp));
            chk("R3", "adc_chsel", 64'(chsel), 64'(sel_exp));
            chk("R4", "oneshot_done", 64'(odone), 64'(m_done));
            chk("R9", "match_pulse", 64'(mpulse), 64'(m_pulse));
            chk("R9", "match_val", 64'(mval), 64'(m_mval));
            chk("R10", "ch_last", 64'(clast), 64'({m_last[1], m_last[0]}));
            chk("R10", "ch_hold", 64'(chold), 64'({m_hold[1], m_hold[0]}));
            if (odone) os_cnt++;
            if (mpulse) mp_cnt++;
            if (pd && !pd_prev && en) pd_rise++;
            low_streak = pd ? 0 : low_streak + 1;
            if (meas_gap) begin
                if (chsel != 0) meas_gap = 1'b0;
                else if (!pd) gap++;
            end
            pd_prev = pd;
        end
        avalid = 1'b0;
        if (chsel != 0) begin
            lat++;
            if (lat == 2) begin
                avalid = 1'b1;
                adata  = adata + 10'd37;
                lat    = 0;
            end
        end else lat = 0;
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int mp0;
        logic [19:0] keep;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(2);
        chk("R1", "reset pd", 64'(pd), 64'(1));
        chk("R1", "reset chsel", 64'(chsel), 64'(0));
        chk("R1", "reset ch_last", 64'(clast), 64'(0));

        // Single shot ignores a non-zero match vector
        oneshot = 1'b1; mvec = 8'h3C; en = 1'b1;
        step(40);
        chk("R4", "oneshot pulses", 64'(os_cnt), 64'(1));
        chk("R4", "no match in oneshot", 64'(mp_cnt), 64'(0));
        chk("R4", "powered down after oneshot", 64'(pd), 64'(1));
        en = 1'b0; step(2);

        // Continuous normal power
        oneshot = 1'b0; lp = 1'b0; mvec = 8'h05; pd_rise = 0; gap = 0; meas_gap = 1'b1;
        en = 1'b1;
        step(80);
        chk("R2", "power-up wait", 64'(gap), 64'(3));
        chk("R5", "no power-down in normal mode", 64'(pd_rise), 64'(0));
        chk("R9", "reports seen", 64'(mp_cnt >= 2), 64'(1));
        chk("R9", "reported vector", 64'(mval), 64'(8'h05));

        mp0 = mp_cnt; mvec = 8'h00;
        step(60);
        chk("R8", "zero vector never reports", 64'(mp_cnt), 64'(mp0));
        for (int i = 0; i < 8; i++) begin
            mvec = i[0] ? 8'h06 : 8'h05;
            step(9);
        end
        chk("R8", "changing vector never reports", 64'(mp_cnt), 64'(mp0));

        keep = clast;
        srst = 1'b1; #1;
        chk("R11", "soft reset pd same cycle", 64'(pd), 64'(1));
        step(3);
        chk("R11", "soft reset chsel", 64'(chsel), 64'(0));
        chk("R11", "soft reset keeps values", 64'(clast), 64'(keep));
        srst = 1'b0;
        step(20);
        en = 1'b0; step(2);

        // Low-power wake loop, then handover
        lp = 1'b1; mvec = 8'h00; pd_rise = 0; en = 1'b1;
        step(100);
        chk("R6", "periodic sleeps", 64'(pd_rise >= 3), 64'(1));
        mp0 = mp_cnt; mvec = 8'h21;
        step(150);
        chk("R7", "stays powered after handover", 64'(low_streak > 60), 64'(1));
        chk("R9", "report after handover", 64'(mp_cnt > mp0), 64'(1));
        chk("R9", "handover vector", 64'(mval), 64'(8'h21));

        // Disable in the middle of a round
        while (chsel == 0) step(1);
        en = 1'b0; #1;
        chk("R12", "disable pd same cycle", 64'(pd), 64'(1));
        step(1);
        chk("R12", "disable chsel", 64'(chsel), 64'(0));

        // Zero-valued counts and times act as one
        pwrup = 4'd0; wake = 24'd0; lpcnt = 8'd0; npcnt = 16'd0; mvec = 8'h80;
        mp0 = mp_cnt; en = 1'b1;
        step(60);
        chk("R8", "zero count reports", 64'(mp_cnt > mp0), 64'(1));
        en = 1'b0; step(3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule